// File: doc/BRIEF.md
# Iterative SHA-1 Compression Core

This block computes the SHA-1 compression function over one 512-bit message block per command, one round per clock. The surrounding logic pads the message and splits it into blocks. It then issues a start-of-message command for the first block and a continue command for each later block. The core keeps the 160-bit chaining value between blocks, so a multi-block message is a sequence of one start followed by any number of continue commands.

The core holds five 32-bit working words and five 32-bit chaining words. It also holds a sixteen-word sliding window that expands the message schedule as the rounds proceed. A start command seeds both the chaining and the working words with the standard initial constants. A continue command seeds the working words from the chaining words already held. After the eightieth round, each chaining word adds its working word modulo 2^32. The core then reports idle and flags the digest as valid.

Top module: `sha1_iter_core`

## Requirements
- R1: After reset, ready_o is 1, digest_valid_o is 0 and digest_o is all zeros.
- R2: A start command (init_i = 1 while ready_o = 1) hashes block_i from the standard initial values; for the padded one-block message "abc" the digest is a9993e364706816aba3e25717850c26c9cd0d89d.
- R3: A continue command (next_i = 1, init_i = 0, while ready_o = 1) hashes block_i starting from the current digest_o; for the standard 56-character two-block message the digest after the first block is f4286818c37b27ae0408f581846771484a566572 and after the second is 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R4: After the clock edge that accepts a command, ready_o is 0 for exactly 81 clock cycles and then returns to 1, with digest_valid_o rising in the same cycle.
- R5: digest_valid_o drops to 0 in the cycle after a command is accepted, and once set it stays at 1 with an unchanged digest_o until the next accepted command.
- R6: init_i, next_i and block_i are ignored while ready_o is 0: the result and the busy time are those of the accepted command.
- R7: digest_o is the chaining words concatenated with word 0 in bits 159:128 and word 4 in bits 31:0.
- R8: While busy, digest_o holds the chaining value the block started from (the initial constants for a start command).
- R9: When init_i and next_i are both 1 while ready_o = 1, the start command wins.
- R10: A continue command issued after reset without any start uses the all-zero chaining value.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start a new message with this block |
| next_i | input | 1 | Continue the current message with this block |
| block_i | input | 512 | Padded message block, first word in bits 511:480 |
| ready_o | output | 1 | Core idle and able to accept a command |
| digest_o | output | 160 | Chaining value / digest |
| digest_valid_o | output | 1 | digest_o holds the result of the last command |

## Verification
The bench compares every result against an arithmetic model of the compression function. It runs the known vectors, a sweep of generated two-block chains, and a continue-from-zero case. A swapped round function or rotate, or a wrong schedule tap, corrupts all of these digests. Chaining errors show up in the second block of each chain and in the check of the busy-time digest. Restarting on a command that arrives mid-block, or latching block_i late, changes both the digest and the 81-cycle busy count. A lost start-over-continue priority gives a digest built on stale chaining. A valid flag that never clears or that arrives a cycle late is caught by sampling it right after acceptance and at the rise of ready.

// File: rtl/sha1_pkg.sv
`timescale 1ns/1ps
package sha1_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } quint_t;

  localparam quint_t IV_C = '{
    a: 32'h67452301,
    b: 32'hEFCDAB89,
    c: 32'h98BADCFE,
    d: 32'h10325476,
    e: 32'hC3D2E1F0
  };

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROUND,
    ST_FINAL
  } ctrl_e;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t stage_k(input logic [1:0] stage);
    case (stage)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

  function automatic word_t stage_f(input logic [1:0] stage, input word_t b,
                                    input word_t c, input word_t d);
    case (stage)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction

endpackage

// File: rtl/sha1_msg_sched.sv
`timescale 1ns/1ps
module sha1_msg_sched #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WINDOW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     shift_i,
  input  logic [WORD_W*WINDOW-1:0] block_i,
  output logic [WORD_W-1:0]        w_o
);

  localparam int unsigned TAP_A = WINDOW - 3;
  localparam int unsigned TAP_B = WINDOW - 8;
  localparam int unsigned TAP_C = WINDOW - 14;

  logic [WORD_W-1:0] win_q [WINDOW];
  logic [WORD_W-1:0] mix;
  logic [WORD_W-1:0] expand;

  assign mix    = win_q[TAP_A] ^ win_q[TAP_B] ^ win_q[TAP_C] ^ win_q[0];
  assign expand = {mix[WORD_W-2:0], mix[WORD_W-1]};
  assign w_o    = win_q[0];

  for (genvar i = 0; i < WINDOW; i++) begin : g_win
    logic [WORD_W-1:0] shift_in;
    if (i == WINDOW - 1) begin : g_tail
      assign shift_in = expand;
    end else begin : g_body
      assign shift_in = win_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[i] <= '0;
      end else if (load_i) begin
        win_q[i] <= block_i[(WINDOW-1-i)*WORD_W +: WORD_W];
      end else if (shift_i) begin
        win_q[i] <= shift_in;
      end
    end
  end

  // R2
  sched_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (w_o == $past(block_i[WORD_W*WINDOW-1 -: WORD_W])));

endmodule

// File: rtl/sha1_round_dp.sv
`timescale 1ns/1ps
module sha1_round_dp
  import sha1_pkg::*;
(
  input  logic [1:0] stage_i,
  input  quint_t     work_i,
  input  word_t      w_i,
  output quint_t     work_o
);

  word_t f_val;
  word_t sum;

  always_comb begin
    f_val    = stage_f(stage_i, work_i.b, work_i.c, work_i.d);
    sum      = rotl(work_i.a, 5) + f_val + work_i.e + stage_k(stage_i) + w_i;
    work_o.a = sum;
    work_o.b = work_i.a;
    work_o.c = rotl(work_i.b, 30);
    work_o.d = work_i.c;
    work_o.e = work_i.d;
  end

endmodule

// File: rtl/sha1_ctrl.sv
`timescale 1ns/1ps
module sha1_ctrl
  import sha1_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS   = 80,
  parameter int unsigned STAGE_ROUNDS = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       next_i,
  output logic       start_o,
  output logic       use_iv_o,
  output logic       round_en_o,
  output logic       final_o,
  output logic [1:0] stage_o,
  output logic       ready_o,
  output logic       valid_o
);

  localparam int unsigned CTR_W = $clog2(NUM_ROUNDS);
  localparam int unsigned SUB_W = $clog2(STAGE_ROUNDS);
  localparam logic [CTR_W-1:0] LAST_RND  = CTR_W'(NUM_ROUNDS - 1);
  localparam logic [SUB_W-1:0] LAST_SUB  = SUB_W'(STAGE_ROUNDS - 1);

  ctrl_e            state_q;
  logic [CTR_W-1:0] ctr_q;
  logic [SUB_W-1:0] sub_q;
  logic [1:0]       stage_q;
  logic             valid_q;

  assign ready_o    = (state_q == ST_IDLE);
  assign start_o    = ready_o && (init_i || next_i);
  assign use_iv_o   = init_i;
  assign round_en_o = (state_q == ST_ROUND);
  assign final_o    = (state_q == ST_FINAL);
  assign stage_o    = stage_q;
  assign valid_o    = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctr_q   <= '0;
      sub_q   <= '0;
      stage_q <= '0;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_o) begin
            state_q <= ST_ROUND;
            ctr_q   <= '0;
            sub_q   <= '0;
            stage_q <= '0;
            valid_q <= 1'b0;
          end
        end
        ST_ROUND: begin
          if (sub_q == LAST_SUB) begin
            sub_q   <= '0;
            stage_q <= stage_q + 2'd1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
          if (ctr_q == LAST_RND) begin
            ctr_q   <= '0;
            state_q <= ST_FINAL;
          end else begin
            ctr_q <= ctr_q + 1'b1;
          end
        end
        ST_FINAL: begin
          state_q <= ST_IDLE;
          valid_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  valid_implies_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);

  // R5
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (init_i || next_i)) |=> (!ready_o && !valid_o));

  // R4
  ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(init_i || next_i));

  // R4
  ctr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_q < CTR_W'(NUM_ROUNDS));

  // R6
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ROUND && ctr_q != LAST_RND) |=>
      (!ready_o && ctr_q == $past(ctr_q) + 1'b1));

endmodule

// File: rtl/sha1_iter_core.sv
`timescale 1ns/1ps
module sha1_iter_core
  import sha1_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS   = 80,
  parameter int unsigned STAGE_ROUNDS = 20,
  parameter int unsigned BLOCK_WORDS  = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              init_i,
  input  logic                              next_i,
  input  logic [BLOCK_WORDS*WORD_W-1:0]     block_i,
  output logic                              ready_o,
  output logic [$bits(quint_t)-1:0]         digest_o,
  output logic                              digest_valid_o
);

  logic       start;
  logic       use_iv;
  logic       round_en;
  logic       final_en;
  logic [1:0] stage;
  word_t      w_cur;
  quint_t     work_q;
  quint_t     work_nxt;
  quint_t     chain_q;

  sha1_ctrl #(
    .NUM_ROUNDS  (NUM_ROUNDS),
    .STAGE_ROUNDS(STAGE_ROUNDS)
  ) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init_i),
    .next_i    (next_i),
    .start_o   (start),
    .use_iv_o  (use_iv),
    .round_en_o(round_en),
    .final_o   (final_en),
    .stage_o   (stage),
    .ready_o   (ready_o),
    .valid_o   (digest_valid_o)
  );

  sha1_msg_sched #(
    .WORD_W(WORD_W),
    .WINDOW(BLOCK_WORDS)
  ) sched_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .shift_i(round_en),
    .block_i(block_i),
    .w_o    (w_cur)
  );

  sha1_round_dp round_i (
    .stage_i(stage),
    .work_i (work_q),
    .w_i    (w_cur),
    .work_o (work_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q  <= '0;
      chain_q <= '0;
    end else if (start) begin
      work_q <= use_iv ? IV_C : chain_q;
      if (use_iv) chain_q <= IV_C;
    end else if (round_en) begin
      work_q <= work_nxt;
    end else if (final_en) begin
      chain_q.a <= chain_q.a + work_q.a;
      chain_q.b <= chain_q.b + work_q.b;
      chain_q.c <= chain_q.c + work_q.c;
      chain_q.d <= chain_q.d + work_q.d;
      chain_q.e <= chain_q.e + work_q.e;
    end
  end

  assign digest_o = chain_q;

  // R8
  busy_digest_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(digest_o));

  // R5
  idle_digest_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digest_valid_o && $past(digest_valid_o)) |-> $stable(digest_o));

endmodule

// File: tb/sha1_iter_core_tb.sv
`timescale 1ns/1ps
module sha1_iter_core_tb_top;

  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0;
  logic         nxt = 1'b0;
  logic [511:0] blk = '0;
  logic         ready;
  logic [159:0] digest;
  logic         dvalid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  sha1_iter_core dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .init_i        (init),
    .next_i        (nxt),
    .block_i       (blk),
    .ready_o       (ready),
    .digest_o      (digest),
    .digest_valid_o(dvalid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [159:0] ref_compress(input logic [159:0] hin,
                                                input logic [511:0] b);
    logic [31:0] w [80];
    logic [31:0] a, bb, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = b[511-32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      t    = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {t[30:0], t[31]};
    end
    a = hin[159:128]; bb = hin[127:96]; c = hin[95:64]; d = hin[63:32]; e = hin[31:0];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (bb & c) | (~bb & d);           k = 32'h5A827999; end
      else if (i < 40) begin f = bb ^ c ^ d;                     k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (bb & c) | (bb & d) | (c & d);  k = 32'h8F1BBCDC; end
      else             begin f = bb ^ c ^ d;                     k = 32'hCA62C1D6; end
      t  = {a[26:0], a[31:27]} + f + e + k + w[i];
      e  = d;
      d  = c;
      c  = {bb[1:0], bb[31:2]};
      bb = a;
      a  = t;
    end
    return {hin[159:128] + a, hin[127:96] + bb, hin[95:64] + c,
            hin[63:32] + d, hin[31:0] + e};
  endfunction

  function automatic logic [511:0] gen_block(input int k);
    logic [511:0] r;
    for (int i = 0; i < 16; i++)
      r[511-32*i -: 32] = (32'h9E3779B9 * 32'(k * 16 + i + 1)) ^ (32'(k) << i);
    return r;
  endfunction

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Issue a command; count busy cycles; optionally disturb inputs mid-block.
  task automatic run_cmd(input logic i_v, input logic n_v, input logic [511:0] b,
                         input int disturb_at, output int lat,
                         output logic v_first, output logic [159:0] busy_dig);
    @(negedge clk);
    init = i_v; nxt = n_v; blk = b;
    @(negedge clk);
    init = 1'b0; nxt = 1'b0; blk = ~b;
    v_first  = dvalid;
    busy_dig = digest;
    lat = 0;
    while (!ready) begin
      lat++;
      if (lat == disturb_at) begin
        init = 1'b1; nxt = 1'b1; blk = gen_block(999);
      end else begin
        init = 1'b0; nxt = 1'b0;
      end
      @(negedge clk);
    end
    init = 1'b0; nxt = 1'b0;
  endtask

  localparam logic [511:0] ABC_BLK =
    512'h61626380000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000018;
  localparam logic [159:0] ABC_DIG = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
  localparam logic [511:0] TWO_B0 =
    512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
  localparam logic [511:0] TWO_B1 =
    512'h000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000001C0;
  localparam logic [159:0] TWO_D0 = 160'hf4286818c37b27ae0408f581846771484a566572;
  localparam logic [159:0] TWO_D1 = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;
  localparam logic [159:0] IV_V   = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;

  initial begin
    int           lat;
    logic         v0;
    logic [159:0] bd;
    logic [159:0] hold;
    logic [159:0] exp0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready after reset", 160'(ready), 160'd1);
    check("R1 valid after reset", 160'(dvalid), 160'd0);
    check("R1 digest after reset", digest, '0);

    // R10 continue from zero chaining
    run_cmd(1'b0, 1'b1, gen_block(7), 0, lat, v0, bd);
    check("R10 next after reset", digest, ref_compress('0, gen_block(7)));
    check("R4 busy cycles", 160'(lat), 160'd81);
    check("R4 valid with ready", 160'(dvalid), 160'd1);

    // R2 start command, known vector
    run_cmd(1'b1, 1'b0, ABC_BLK, 0, lat, v0, bd);
    check("R2 abc digest", digest, ABC_DIG);
    check("R7 word0 in msb", 160'(digest[159:128]), 160'(32'ha9993e36));
    check("R8 busy digest is iv", bd, IV_V);
    check("R5 valid cleared after accept", 160'(v0), 160'd0);
    check("R4 busy cycles abc", 160'(lat), 160'd81);

    // R5 valid and digest hold while idle
    hold = digest;
    repeat (10) @(negedge clk);
    check("R5 valid holds", 160'(dvalid), 160'd1);
    check("R5 digest holds", digest, hold);

    // R3 two-block known vector
    run_cmd(1'b1, 1'b0, TWO_B0, 0, lat, v0, bd);
    check("R3 first block", digest, TWO_D0);
    run_cmd(1'b0, 1'b1, TWO_B1, 0, lat, v0, bd);
    check("R3 second block", digest, TWO_D1);
    check("R8 busy digest is chaining", bd, TWO_D0);

    // R6 commands and block changes while busy are ignored
    run_cmd(1'b1, 1'b0, ABC_BLK, 40, lat, v0, bd);
    check("R6 digest unaffected", digest, ABC_DIG);
    check("R6 busy cycles unaffected", 160'(lat), 160'd81);

    // R9 init wins over next (chaining currently abc)
    run_cmd(1'b1, 1'b1, TWO_B0, 0, lat, v0, bd);
    check("R9 init priority", digest, TWO_D0);

    // R2 R3 sweep of generated two-block chains
    for (int k = 0; k < 16; k++) begin
      run_cmd(1'b1, 1'b0, gen_block(k), 0, lat, v0, bd);
      exp0 = ref_compress(IV_V, gen_block(k));
      check("R2 sweep start", digest, exp0);
      run_cmd(1'b0, 1'b1, gen_block(k + 100), 0, lat, v0, bd);
      check("R3 sweep continue", digest, ref_compress(exp0, gen_block(k + 100)));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule